// File: doc/BRIEF.md
# External Bus Hold Handshake Controller

This controller lets an outside bus master borrow the shared external memory bus from the memory interface it sits in. The master pulls an asynchronous, active-low request line. The controller brings that line into the core clock domain through a flip-flop synchronizer. It lets any access that is already running finish and stops granting new ones. When the memory is configured as SDRAM, it then precharges the open banks and runs one refresh. After that it releases every bus output except the clock outputs, and only then drives its active-low acknowledge.

When the master lets the request go, the controller drops the acknowledge and turns its outputs back on in the same cycle. With SDRAM it precharges and refreshes once more. Refresh timer ticks that arrived while the bus was lent out are held in a small saturating backlog, and this backlog is now worked off with back-to-back refreshes. Normal access granting resumes after that.

A bus-request indicator tells the outside world that the access engine has work, whatever the hold state. A configuration input can turn off hold handling altogether. The precharge and refresh sequences themselves belong to neighbouring engines. This block talks to them through level request / single-cycle done handshakes.

Top module: `ext_hold_ctrl`

## Requirements
- R1: `hold_req_n` passes through a two-stage synchronizer before use. With the bus idle and `sdram_cfg`=0, after `hold_req_n` falls just before rising edge 1, `bus_oe` is still 1 after edge 3, goes 0 at edge 4, and `hold_ack_n` goes 0 at edge 5.
- R2: A hold request waits for a running access (`acc_busy`=1) to finish. While the access runs, `bus_oe` and `hold_ack_n` stay 1. Once the synchronized request is seen, `acc_grant` is 0, because hold outranks every other request.
- R3: With `sdram_cfg`=1 the surrender sequence is, in strict order: the first cycle with `pre_req`=1, the first cycle with `ref_req`=1, the first cycle with `bus_oe`=0, and then the first cycle with `hold_ack_n`=0.
- R4: `hold_ack_n` is 0 only while `bus_oe` is 0, and it first falls after at least one full cycle of `bus_oe`=0. `clk_oe` stays 1 at all times.
- R5: After `hold_req_n` rises just before edge 1, `hold_ack_n` is still 0 after edge 2, and both `hold_ack_n` and `bus_oe` return to 1 at edge 3.
- R6: With `sdram_cfg`=1, after release exactly one precharge and at least one refresh complete before `acc_grant` returns to 1.
- R7: While the bus is held, each `refresh_tick` adds one to `pend_cnt`, which saturates at 7, and `pre_req` and `ref_req` stay 0.
- R8: After release, every backlogged refresh is issued on a continuously requested `ref_req`. `pend_cnt` drops by one per `ref_done`, and grant resumes when it reaches 0. A full backlog of 7 plus the release refresh means 8 refreshes within 24 cycles of the acknowledge rising.
- R9: `bus_req` is 1 whenever `acc_pending` or `acc_busy` is 1, including while the bus is held.
- R10: While `hold_disable`=1, a hold request has no effect: `hold_ack_n` and `bus_oe` stay 1 and `acc_grant` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_req_n | input | 1 | Asynchronous active-low bus request from the outside master |
| hold_ack_n | output | 1 | Active-low acknowledge: the bus outputs are released |
| hold_disable | input | 1 | Configuration: 1 ignores hold requests |
| sdram_cfg | input | 1 | Configuration: some memory region is SDRAM |
| acc_pending | input | 1 | Access engine has a queued request |
| acc_busy | input | 1 | Access engine has an access on the bus |
| acc_grant | output | 1 | Access engine may start a new access |
| bus_req | output | 1 | Bus-request indicator to the outside |
| pre_req | output | 1 | Ask the SDRAM engine to precharge all banks |
| pre_done | input | 1 | Single-cycle precharge completion |
| ref_req | output | 1 | Ask the SDRAM engine for one refresh |
| ref_done | input | 1 | Single-cycle refresh completion |
| refresh_tick | input | 1 | Refresh timer request pulse |
| bus_oe | output | 1 | Enable for address, data and control outputs |
| clk_oe | output | 1 | Enable for the clock outputs |
| pend_cnt | output | 3 | Refresh backlog count |

## Verification
The hardest condition to reach is a fully saturated refresh backlog that then has to be replayed at release. That state exists only after the whole SDRAM surrender sequence has finished and the acknowledge is low. The bench's handshake responders answer precharge and refresh requests automatically, so the sequence runs without scripting. The bench then waits for the acknowledge, fires more timer ticks than the backlog can hold, and checks for silence on both SDRAM request lines. It then releases the request and counts refresh completions until grant returns.

// File: rtl/ehc_pkg.sv
package ehc_pkg;
   typedef enum logic [3:0] {
      ST_RUN,      // normal service
      ST_RREF,     // backlog refresh during normal service
      ST_DRAIN,    // wait for running access to finish
      ST_PRE_OUT,  // precharge before surrender
      ST_REF_OUT,  // refresh before surrender
      ST_FLOAT,    // outputs released, acknowledge not yet given
      ST_HELD,     // bus lent out
      ST_RECLAIM,  // outputs back on
      ST_PRE_IN,   // precharge after return
      ST_REF_IN,   // refresh after return
      ST_REPLAY    // work off deferred refreshes
   } ehc_state_t;
endpackage

// File: rtl/ehc_sync.sv
module ehc_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("ehc_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] ff;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) ff[0] <= RST_VAL;
            else        ff[0] <= d;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) ff[i] <= RST_VAL;
            else        ff[i] <= ff[i-1];
      end
   end

   assign q = ff[STAGES-1];
endmodule

// File: rtl/ehc_backlog.sv
module ehc_backlog #(
   parameter int MAX = 7,
   parameter int W   = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   input  logic         dec,
   output logic [W-1:0] cnt,
   output logic         zero
);
   if (MAX < 1 || MAX >= (1 << W)) begin : g_bad_max
      $error("ehc_backlog: MAX does not fit in W bits");
   end

   localparam logic [W-1:0] TOP = W'(MAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else begin
         unique case ({inc, dec})
            2'b10:   if (cnt != TOP) cnt <= cnt + 1'b1;
            2'b01:   if (cnt != '0)  cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   assign zero = (cnt == '0);
endmodule

// File: rtl/ehc_seq.sv
module ehc_seq
   import ehc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       hold_seen,
   input  logic       hold_disable,
   input  logic       sdram_en,
   input  logic       acc_busy,
   input  logic       pre_done,
   input  logic       ref_done,
   input  logic       backlog_zero,
   output ehc_state_t st
);
   ehc_state_t nxt;
   logic       take;

   assign take = hold_seen && !hold_disable;

   always_comb begin
      nxt = st;
      unique case (st)
         ST_RUN:
            if (take)                                     nxt = ST_DRAIN;
            else if (sdram_en && !backlog_zero && !acc_busy) nxt = ST_RREF;
         ST_RREF:    if (ref_done)  nxt = ST_RUN;
         ST_DRAIN:   if (!acc_busy) nxt = sdram_en ? ST_PRE_OUT : ST_FLOAT;
         ST_PRE_OUT: if (pre_done)  nxt = ST_REF_OUT;
         ST_REF_OUT: if (ref_done)  nxt = ST_FLOAT;
         ST_FLOAT:                  nxt = ST_HELD;
         ST_HELD:    if (!hold_seen) nxt = ST_RECLAIM;
         ST_RECLAIM:                nxt = sdram_en ? ST_PRE_IN : ST_REPLAY;
         ST_PRE_IN:  if (pre_done)  nxt = ST_REF_IN;
         ST_REF_IN:  if (ref_done)  nxt = ST_REPLAY;
         ST_REPLAY:  if (backlog_zero) nxt = ST_RUN;
         default:                   nxt = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) st <= ST_RUN;
      else        st <= nxt;
endmodule

// File: rtl/ext_hold_ctrl.sv
module ext_hold_ctrl
   import ehc_pkg::*;
#(
   parameter int SYNC_STAGES   = 2,
   parameter int DEFER_MAX     = 7,
   parameter bit SDRAM_SUPPORT = 1'b1,
   localparam int CNT_W        = $clog2(DEFER_MAX + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hold_req_n,
   output logic             hold_ack_n,
   input  logic             hold_disable,
   input  logic             sdram_cfg,
   input  logic             acc_pending,
   input  logic             acc_busy,
   output logic             acc_grant,
   output logic             bus_req,
   output logic             pre_req,
   input  logic             pre_done,
   output logic             ref_req,
   input  logic             ref_done,
   input  logic             refresh_tick,
   output logic             bus_oe,
   output logic             clk_oe,
   output logic [CNT_W-1:0] pend_cnt
);
   if (DEFER_MAX < 1) begin : g_bad_defer
      $error("ext_hold_ctrl: DEFER_MAX must be at least 1");
   end

   logic       req_sync_n;
   logic       hold_seen;
   logic       sdram_en;
   logic       backlog_zero;
   logic       backlog_dec;
   ehc_state_t st;

   ehc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(hold_req_n), .q(req_sync_n)
   );
   assign hold_seen = !req_sync_n;

   if (SDRAM_SUPPORT) begin : g_sdram
      assign sdram_en = sdram_cfg;
   end else begin : g_nosdram
      logic unused_cfg;
      assign unused_cfg = sdram_cfg;
      assign sdram_en   = 1'b0;
   end

   ehc_seq u_seq (
      .clk(clk), .rst_n(rst_n), .hold_seen(hold_seen),
      .hold_disable(hold_disable), .sdram_en(sdram_en),
      .acc_busy(acc_busy), .pre_done(pre_done), .ref_done(ref_done),
      .backlog_zero(backlog_zero), .st(st)
   );

   assign backlog_dec = ref_done && (st == ST_RREF || st == ST_REPLAY);

   ehc_backlog #(.MAX(DEFER_MAX), .W(CNT_W)) u_backlog (
      .clk(clk), .rst_n(rst_n),
      .inc(refresh_tick && sdram_en), .dec(backlog_dec),
      .cnt(pend_cnt), .zero(backlog_zero)
   );

   assign hold_ack_n = (st != ST_HELD);
   assign bus_oe     = !(st == ST_FLOAT || st == ST_HELD);
   assign clk_oe     = 1'b1;
   assign pre_req    = (st == ST_PRE_OUT) || (st == ST_PRE_IN);
   assign ref_req    = (st == ST_REF_OUT) || (st == ST_REF_IN) || (st == ST_RREF)
                    || (st == ST_REPLAY && !backlog_zero);
   assign acc_grant  = (st == ST_RUN) && !(hold_seen && !hold_disable)
                    && !(sdram_en && !backlog_zero && !acc_busy);
   assign bus_req    = acc_pending || acc_busy;
endmodule

// File: rtl/ehc_chk.sv
module ehc_chk #(
   parameter int DEFER_MAX = 7,
   parameter int CNT_W     = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             hold_ack_n,
   input logic             bus_oe,
   input logic             pre_req,
   input logic             ref_req,
   input logic             acc_grant,
   input logic [CNT_W-1:0] pend_cnt
);
   p_ack_needs_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !hold_ack_n |-> !bus_oe);

   p_off_before_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hold_ack_n) |-> $past(!bus_oe));

   p_oe_with_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hold_ack_n) |-> bus_oe);

   p_quiet_while_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !hold_ack_n |-> (!pre_req && !ref_req));

   p_no_grant_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_oe |-> !acc_grant);

   p_backlog_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      int'(pend_cnt) <= DEFER_MAX);

   p_backlog_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(pend_cnt) - int'($past(pend_cnt)) <= 1) &&
      (int'($past(pend_cnt)) - int'(pend_cnt) <= 1));
endmodule

bind ext_hold_ctrl ehc_chk #(.DEFER_MAX(DEFER_MAX), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .hold_ack_n(hold_ack_n), .bus_oe(bus_oe),
   .pre_req(pre_req), .ref_req(ref_req), .acc_grant(acc_grant),
   .pend_cnt(pend_cnt)
);

// File: tb/ext_hold_ctrl_test.sv
`timescale 1ns/1ps
module ext_hold_ctrl_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hold_req_n = 1'b1, hold_disable = 1'b0, sdram_cfg = 1'b0;
   logic acc_pending = 1'b0, acc_busy = 1'b0, refresh_tick = 1'b0;
   logic pre_done = 1'b0, ref_done = 1'b0;
   logic hold_ack_n, acc_grant, bus_req, pre_req, ref_req, bus_oe, clk_oe;
   logic [2:0] pend_cnt;

   int tests = 0, fails = 0, cyc = 0, ref_pulses = 0, pre_pulses = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   ext_hold_ctrl uut (
      .clk(clk), .rst_n(rst_n), .hold_req_n(hold_req_n), .hold_ack_n(hold_ack_n),
      .hold_disable(hold_disable), .sdram_cfg(sdram_cfg),
      .acc_pending(acc_pending), .acc_busy(acc_busy), .acc_grant(acc_grant),
      .bus_req(bus_req), .pre_req(pre_req), .pre_done(pre_done),
      .ref_req(ref_req), .ref_done(ref_done), .refresh_tick(refresh_tick),
      .bus_oe(bus_oe), .clk_oe(clk_oe), .pend_cnt(pend_cnt)
   );

   // SDRAM engine model: answers a level request with a one-cycle done
   always @(negedge clk) begin
      cyc = cyc + 1;
      if (ref_done) ref_pulses = ref_pulses + 1;
      if (pre_done) pre_pulses = pre_pulses + 1;
      pre_done <= pre_req && !pre_done;
      ref_done <= ref_req && !ref_done;
   end

   task automatic chk(input string tag, input int act, input int exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wait_ack(input int lim, output bit seen);
      seen = 1'b0;
      for (int i = 0; i < lim && !seen; i++) begin
         @(negedge clk);
         if (!hold_ack_n) seen = 1'b1;
      end
   endtask

   task automatic wait_grant(input int lim, output int n);
      n = -1;
      for (int i = 0; i < lim && n < 0; i++) begin
         @(negedge clk);
         if (acc_grant) n = i;
      end
   endtask

   task automatic t_reset;
      chk("R4 reset ack_n", hold_ack_n, 1);
      chk("R4 reset bus_oe", bus_oe, 1);
      chk("R4 clk_oe", clk_oe, 1);
      chk("R10 reset grant", acc_grant, 1);
      chk("R7 reset pend", pend_cnt, 0);
      chk("R9 reset bus_req", bus_req, 0);
   endtask

   task automatic t_latency;
      sdram_cfg = 1'b0;
      @(negedge clk); hold_req_n = 1'b0;
      repeat (3) @(posedge clk); #1;
      chk("R1 oe after edge3", bus_oe, 1);
      @(posedge clk); #1;
      chk("R1 oe after edge4", bus_oe, 0);
      chk("R1 ack after edge4", hold_ack_n, 1);
      @(posedge clk); #1;
      chk("R1 ack after edge5", hold_ack_n, 0);
      chk("R4 clk_oe held", clk_oe, 1);
      repeat (3) @(negedge clk);
      hold_req_n = 1'b1;
      repeat (2) @(posedge clk); #1;
      chk("R5 ack after edge2", hold_ack_n, 0);
      @(posedge clk); #1;
      chk("R5 ack after edge3", hold_ack_n, 1);
      chk("R5 oe after edge3", bus_oe, 1);
      repeat (3) @(negedge clk);
      chk("R5 grant back", acc_grant, 1);
   endtask

   task automatic t_busy;
      bit seen;
      sdram_cfg = 1'b0;
      @(negedge clk); acc_busy = 1'b1; hold_req_n = 1'b0;
      repeat (8) @(negedge clk);
      chk("R2 oe during access", bus_oe, 1);
      chk("R2 ack during access", hold_ack_n, 1);
      chk("R2 grant blocked", acc_grant, 0);
      acc_busy = 1'b0; acc_pending = 1'b1;
      wait_ack(10, seen);
      chk("R2 ack after access", seen, 1);
      chk("R9 bus_req while held", bus_req, 1);
      acc_pending = 1'b0;
      @(negedge clk);
      chk("R9 bus_req idle", bus_req, 0);
      hold_req_n = 1'b1;
      repeat (6) @(negedge clk);
   endtask

   task automatic t_sdram;
      int t_pre = -1, t_ref = -1, t_off = -1, t_ack = -1, n;
      int p0, r0;
      sdram_cfg = 1'b1;
      @(negedge clk); hold_req_n = 1'b0;
      for (int i = 0; i < 40 && t_ack < 0; i++) begin
         @(negedge clk);
         if (pre_req && t_pre < 0) t_pre = cyc;
         if (ref_req && t_ref < 0) t_ref = cyc;
         if (!bus_oe && t_off < 0) t_off = cyc;
         if (!hold_ack_n && t_ack < 0) t_ack = cyc;
      end
      chk("R3 pre seen", int'(t_pre >= 0), 1);
      chk("R3 pre before ref", int'(t_pre < t_ref), 1);
      chk("R3 ref before oe off", int'(t_ref < t_off), 1);
      chk("R3 oe off before ack", int'(t_off < t_ack), 1);
      repeat (3) @(negedge clk);
      p0 = pre_pulses; r0 = ref_pulses;
      hold_req_n = 1'b1;
      wait_grant(40, n);
      chk("R6 grant returns", int'(n >= 0), 1);
      chk("R6 one precharge", pre_pulses - p0, 1);
      chk("R6 refresh done", int'(ref_pulses - r0 >= 1), 1);
      sdram_cfg = 1'b0;
   endtask

   task automatic t_backlog;
      bit seen;
      int r0, n, quiet = 1;
      sdram_cfg = 1'b1;
      @(negedge clk); hold_req_n = 1'b0;
      wait_ack(40, seen);
      chk("R7 held", seen, 1);
      r0 = ref_pulses;
      refresh_tick = 1'b1;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         if (pre_req || ref_req) quiet = 0;
      end
      refresh_tick = 1'b0;
      @(negedge clk);
      chk("R7 count 3", pend_cnt, 3);
      refresh_tick = 1'b1;
      for (int i = 0; i < 7; i++) begin
         @(negedge clk);
         if (pre_req || ref_req) quiet = 0;
      end
      refresh_tick = 1'b0;
      @(negedge clk);
      chk("R7 saturates at 7", pend_cnt, 7);
      chk("R7 no sdram request while held", quiet, 1);
      chk("R7 no refresh while held", ref_pulses - r0, 0);
      hold_req_n = 1'b1;
      for (int i = 0; i < 4 && !hold_ack_n; i++) @(negedge clk);
      r0 = ref_pulses;
      wait_grant(24, n);
      chk("R8 grant within window", int'(n >= 0), 1);
      chk("R8 refresh count", ref_pulses - r0, 8);
      chk("R8 backlog empty", pend_cnt, 0);
      sdram_cfg = 1'b0;
   endtask

   task automatic t_disable;
      int bad = 0;
      hold_disable = 1'b1;
      @(negedge clk); hold_req_n = 1'b0;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (!hold_ack_n || !bus_oe || !acc_grant) bad++;
      end
      chk("R10 hold ignored", bad, 0);
      chk("R10 ack high", hold_ack_n, 1);
      hold_req_n = 1'b1;
      repeat (4) @(negedge clk);
      hold_disable = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_latency();
      t_busy();
      t_sdram();
      t_backlog();
      t_disable();
      if (!finished) begin
         finished = 1'b1;
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         tests++; fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule